// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block gathers the event strobes of a USB host controller into seven sticky status flags that software reads and clears over a small register bus. The strobes come from the frame timer, the root hub, the resume detector, the done-head writeback engine and the scheduler. A separate system-error input also feeds it. Each flag has its own set condition: a toggle of the frame number's top bit, a rising edge of device resume signalling, a plain strobe, and so on. A software write of 1 to a flag clears it.

The block also drives a few control outputs. A start-of-frame token request is raised in the same cycle as its status flag. A writeback inhibit stays high while the done-head flag is set. A halt output is held while the unrecoverable-error flag is set. A combined interrupt-pending line is high whenever any flag is set. A two-bit scheduling overrun counter sits beside the flags and is read at its own bus address.

Top module: `usbh_irq_status`

## Requirements
- R1: After a synchronous reset, all seven flags, the overrun counter, the read data and all outputs are 0.
- R2: A write to address 0 clears every flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged. Flag positions are: bit 6 root hub change, bit 5 frame overflow, bit 4 unrecoverable error, bit 3 resume, bit 2 start of frame, bit 1 done-head written, bit 0 schedule overrun.
- R3: When a set event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: Bit 6 is set one cycle after a root hub change strobe, or after a change strobe on any downstream port.
- R5: On a frame update strobe, bit 5 is set if the frame number MSB differs from the MSB latched at the previous update. The latched MSB is 0 after reset. Both 0 to 1 and 1 to 0 count.
- R6: A frame update strobe sets bit 2. It also pulses `sof_token_o` for one cycle, in the same cycle that bit 2 becomes 1.
- R7: Bit 3 is set only by a 0 to 1 change of the device resume line. That change does not set it while `host_resume_i` is high. A level held high sets nothing further.
- R8: A done-head writeback strobe sets bit 1. `wdh_inhibit_o` is high exactly while bit 1 is 1.
- R9: A schedule overrun strobe sets bit 0 and advances the 2-bit overrun counter, which wraps from 3 to 0. The counter reads at address 1 in bits 1:0. Writes to address 1 have no effect.
- R10: A system-error input sets bit 4 and `halt_o` follows that bit. Bus writes cannot clear bit 4; only reset clears it.
- R11: Read data is registered. It shows, one cycle after the address is presented, the value held before that edge. Bits above the field read as 0. `irq_o` is the OR of the seven flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| rh_change_i | input | 1 | Root hub status content changed |
| port_change_i | input | NPORT | Per downstream port status changed |
| frame_upd_i | input | 1 | Frame number updated (start of frame) |
| frame_msb_i | input | 1 | Frame number MSB after the update |
| resume_i | input | 1 | Device resume signalling level |
| host_resume_i | input | 1 | Host itself driving resume state |
| wdh_done_i | input | 1 | Done-head writeback completed |
| sched_ovr_i | input | 1 | Frame schedule overrun |
| sys_err_i | input | 1 | Non-USB system error |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Any flag set |
| sof_token_o | output | 1 | Start-of-frame token request |
| wdh_inhibit_o | output | 1 | Block further done-head writebacks |
| halt_o | output | 1 | Stop all processing and signalling |

## Verification
The flags are driven by sparse random strobes mixed with random clear writes. This separates a correct set/clear merge from one where the clear wins or leaks into neighbouring bits. Frame MSB sequences that hold, rise and fall distinguish a true toggle detector from a plain level or rising-edge detector. Resume sequences with the host-resume gate high and low, and with the level held, tell edge detection apart from level sensing. Counter reads across more than four overruns expose a missing or wrong wrap.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int NFLAGS    = 7;
  localparam int FLG_SO    = 0;
  localparam int FLG_WDH   = 1;
  localparam int FLG_SF    = 2;
  localparam int FLG_RD    = 3;
  localparam int FLG_UE    = 4;
  localparam int FLG_FNO   = 5;
  localparam int FLG_RHSC  = 6;
  localparam int ADR_FLAGS = 0;
  localparam int ADR_OVCNT = 1;
  typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/usbh_irq_evt.sv
module usbh_irq_evt
  import usbh_irq_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rh_change_i,
  input  logic [NPORT-1:0] port_change_i,
  input  logic             frame_upd_i,
  input  logic             frame_msb_i,
  input  logic             resume_i,
  input  logic             host_resume_i,
  input  logic             wdh_done_i,
  input  logic             sched_ovr_i,
  input  logic             sys_err_i,
  output flag_vec_t        set_o
);
  logic msb_seen_q;
  logic resume_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_seen_q    <= 1'b0;
      resume_prev_q <= 1'b0;
    end else begin
      if (frame_upd_i) msb_seen_q <= frame_msb_i;
      resume_prev_q <= resume_i;
    end
  end

  always_comb begin
    set_o           = '0;
    set_o[FLG_RHSC] = rh_change_i | (|port_change_i);
    set_o[FLG_FNO]  = frame_upd_i & (frame_msb_i ^ msb_seen_q);
    set_o[FLG_UE]   = sys_err_i;
    set_o[FLG_RD]   = resume_i & ~resume_prev_q & ~host_resume_i;
    set_o[FLG_SF]   = frame_upd_i;
    set_o[FLG_WDH]  = wdh_done_i;
    set_o[FLG_SO]   = sched_ovr_i;
  end
endmodule

// File: rtl/usbh_irq_sticky.sv
module usbh_irq_sticky #(
  parameter bit CLEARABLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic clr_eff;
  assign clr_eff = CLEARABLE ? clr_i : 1'b0;

  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_eff) q_o <= 1'b0;
  end
endmodule

// File: rtl/usbh_irq_ovrcnt.sv
module usbh_irq_ovrcnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
  import usbh_irq_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rh_change_i,
  input  logic [NPORT-1:0]  port_change_i,
  input  logic              frame_upd_i,
  input  logic              frame_msb_i,
  input  logic              resume_i,
  input  logic              host_resume_i,
  input  logic              wdh_done_i,
  input  logic              sched_ovr_i,
  input  logic              sys_err_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sof_token_o,
  output logic              wdh_inhibit_o,
  output logic              halt_o
);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_FLAGS);
  localparam logic [ADDR_W-1:0] A_OVCNT = ADDR_W'(ADR_OVCNT);

  flag_vec_t        set_vec;
  flag_vec_t        clr_vec;
  flag_vec_t        status_q;
  logic [CNT_W-1:0] ovr_cnt_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:NFLAGS];

  usbh_irq_evt #(.NPORT(NPORT)) u_evt (
    .clk           (clk),
    .rst           (rst),
    .rh_change_i   (rh_change_i),
    .port_change_i (port_change_i),
    .frame_upd_i   (frame_upd_i),
    .frame_msb_i   (frame_msb_i),
    .resume_i      (resume_i),
    .host_resume_i (host_resume_i),
    .wdh_done_i    (wdh_done_i),
    .sched_ovr_i   (sched_ovr_i),
    .sys_err_i     (sys_err_i),
    .set_o         (set_vec)
  );

  assign clr_vec = (bus_wr_i && bus_addr_i == A_FLAGS) ? bus_wdata_i[NFLAGS-1:0] : '0;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    usbh_irq_sticky #(.CLEARABLE(i != FLG_UE)) u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (status_q[i])
    );
  end

  usbh_irq_ovrcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (sched_ovr_i),
    .cnt_o (ovr_cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      sof_token_o <= 1'b0;
    end else begin
      sof_token_o <= frame_upd_i;
      bus_rdata_o <= '0;
      if (bus_addr_i == A_FLAGS)      bus_rdata_o[NFLAGS-1:0] <= status_q;
      else if (bus_addr_i == A_OVCNT) bus_rdata_o[CNT_W-1:0]  <= ovr_cnt_q;
    end
  end

  assign irq_o         = |status_q;
  assign wdh_inhibit_o = status_q[FLG_WDH];
  assign halt_o        = status_q[FLG_UE];
endmodule

// File: rtl/usbh_irq_status_chk.sv
module usbh_irq_status_chk #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_upd_i,
  input logic              sof_token_o,
  input logic [6:0]        status,
  input logic              halt_o,
  input logic              wdh_done_i,
  input logic              wdh_inhibit_o,
  input logic              sched_ovr_i,
  input logic [CNT_W-1:0]  ovr_cnt,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [6:0]        wlow
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (status == '0 && ovr_cnt == '0)); // R1
  AST_SOF_PAIR: assert property (@(posedge clk) disable iff (rst) frame_upd_i |=> (sof_token_o && status[2])); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halt_o |=> halt_o); // R10
  AST_WDH_SET_WINS: assert property (@(posedge clk) disable iff (rst) wdh_done_i |=> wdh_inhibit_o); // R3
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wdh_inhibit_o && !(bus_wr_i && bus_addr_i == '0 && wlow[1])) |=> wdh_inhibit_o); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    sched_ovr_i |=> ovr_cnt == CNT_W'($past(ovr_cnt) + 1'b1)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !sched_ovr_i |=> $stable(ovr_cnt)); // R9
endmodule

bind usbh_irq_status usbh_irq_status_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_upd_i   (frame_upd_i),
  .sof_token_o   (sof_token_o),
  .status        (status_q),
  .halt_o        (halt_o),
  .wdh_done_i    (wdh_done_i),
  .wdh_inhibit_o (wdh_inhibit_o),
  .sched_ovr_i   (sched_ovr_i),
  .ovr_cnt       (ovr_cnt_q),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .wlow          (bus_wdata_i[6:0])
);

// File: tb/usbh_irq_status_bench.sv
module usbh_irq_status_bench;
  localparam int NPORT = 2;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rh_change_i = 0, frame_upd_i = 0, frame_msb_i = 0, resume_i = 0;
  logic host_resume_i = 0, wdh_done_i = 0, sched_ovr_i = 0, sys_err_i = 0;
  logic [NPORT-1:0]  port_change_i = '0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic              bus_wr_i = 0;
  logic [DATA_W-1:0] bus_wdata_i = '0;
  logic [DATA_W-1:0] bus_rdata_o;
  logic irq_o, sof_token_o, wdh_inhibit_o, halt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [6:0] m_st;
  logic [1:0] m_cnt;
  logic       m_msb, m_res;

  always #10 clk = ~clk;

  usbh_irq_status #(.NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_usbh_irq_status (
    .clk(clk), .rst(rst), .rh_change_i(rh_change_i), .port_change_i(port_change_i),
    .frame_upd_i(frame_upd_i), .frame_msb_i(frame_msb_i), .resume_i(resume_i),
    .host_resume_i(host_resume_i), .wdh_done_i(wdh_done_i), .sched_ovr_i(sched_ovr_i),
    .sys_err_i(sys_err_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
    .sof_token_o(sof_token_o), .wdh_inhibit_o(wdh_inhibit_o), .halt_o(halt_o));

  function automatic logic [6:0] f_set();
    logic [6:0] s;
    s[6] = rh_change_i | (|port_change_i);
    s[5] = frame_upd_i & (frame_msb_i ^ m_msb);
    s[4] = sys_err_i;
    s[3] = resume_i & ~m_res & ~host_resume_i;
    s[2] = frame_upd_i;
    s[1] = wdh_done_i;
    s[0] = sched_ovr_i;
    return s;
  endfunction

  function automatic logic [6:0] f_clr();
    if (bus_wr_i && bus_addr_i == 0) return bus_wdata_i[6:0] & 7'b110_1111;
    return 7'b0;
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [DATA_W-1:0] exp_rd;
    logic [6:0] nst;
    logic       sof;
    exp_rd = '0;
    if (bus_addr_i == 0) exp_rd[6:0] = m_st;
    else if (bus_addr_i == 1) exp_rd[1:0] = m_cnt;
    nst = f_set() | (m_st & ~f_clr());
    sof = frame_upd_i;
    if (frame_upd_i) m_msb = frame_msb_i;
    m_res = resume_i;
    if (sched_ovr_i) m_cnt = m_cnt + 2'd1;
    m_st = nst;
    @(posedge clk);
    @(negedge clk);
    chk("R11 rdata", bus_rdata_o, exp_rd);
    chk("R11 irq", {31'b0, irq_o}, {31'b0, |m_st});
    chk("R6 sof", {31'b0, sof_token_o}, {31'b0, sof});
    chk("R8 inhibit", {31'b0, wdh_inhibit_o}, {31'b0, m_st[1]});
    chk("R10 halt", {31'b0, halt_o}, {31'b0, m_st[4]});
  endtask

  task automatic idle();
    rh_change_i = 0; port_change_i = '0; frame_upd_i = 0; wdh_done_i = 0;
    sched_ovr_i = 0; sys_err_i = 0; bus_wr_i = 0; bus_wdata_i = '0;
  endtask

  task automatic read_st(input string req, input logic [6:0] exp);
    idle(); bus_addr_i = 0; step();
    chk(req, bus_rdata_o, {25'b0, exp});
  endtask

  task automatic wr(input int a, input logic [6:0] d);
    idle(); bus_addr_i = ADDR_W'(a); bus_wr_i = 1; bus_wdata_i = {25'h1ff_ffff, d}; step();
  endtask

  task automatic do_reset();
    rst = 1; idle(); resume_i = 0; host_resume_i = 0; frame_msb_i = 0; bus_addr_i = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
    m_st = '0; m_cnt = '0; m_msb = 0; m_res = 0;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk("R1 rdata", bus_rdata_o, '0);
    chk("R1 outs", {28'b0, irq_o, sof_token_o, wdh_inhibit_o, halt_o}, '0);
    bus_addr_i = 1; step(); chk("R1 cnt", bus_rdata_o, '0);

    // R4 each source
    idle(); port_change_i = 2'b10; step(); read_st("R4 port", 7'h40);
    wr(0, 7'h40); read_st("R2 clear", 7'h00);
    idle(); rh_change_i = 1; step(); read_st("R4 rh", 7'h40);
    wr(0, 7'h3f); read_st("R2 zero no effect", 7'h40);
    wr(0, 7'h40);

    // R5 toggle both ways, R6
    idle(); frame_upd_i = 1; frame_msb_i = 0; step(); read_st("R5 no toggle", 7'h04);
    chk("R6 sof idle", {31'b0, sof_token_o}, 0);
    idle(); frame_upd_i = 1; frame_msb_i = 1; step(); read_st("R5 rise", 7'h24);
    wr(0, 7'h24);
    idle(); frame_msb_i = 0; step(); read_st("R5 no update", 7'h00);
    idle(); frame_upd_i = 1; frame_msb_i = 0; step(); read_st("R5 fall", 7'h24);
    wr(0, 7'h7f);

    // R7 resume edge
    idle(); host_resume_i = 1; resume_i = 1; step(); read_st("R7 host gated", 7'h00);
    idle(); resume_i = 0; host_resume_i = 0; step();
    resume_i = 1; step(); read_st("R7 edge", 7'h08);
    wr(0, 7'h08); step(); read_st("R7 held level", 7'h00);
    resume_i = 0;

    // R3 set beats clear
    idle(); wdh_done_i = 1; bus_addr_i = 0; bus_wr_i = 1; bus_wdata_i = 32'h2; step();
    read_st("R3 set wins", 7'h02);
    chk("R8 inhibit high", {31'b0, wdh_inhibit_o}, 1);
    wr(0, 7'h02); read_st("R8 cleared", 7'h00);

    // R9 counter wrap, writes ignored
    for (int k = 0; k < 5; k++) begin idle(); sched_ovr_i = 1; step(); end
    wr(1, 7'h7f);
    idle(); bus_addr_i = 1; step(); chk("R9 wrap", bus_rdata_o, 32'd1);
    read_st("R9 flag", 7'h01);
    wr(0, 7'h01);

    // R10 unrecoverable error
    idle(); sys_err_i = 1; step(); wr(0, 7'h7f); read_st("R10 not clearable", 7'h10);
    do_reset();
    chk("R10 reset clears", {31'b0, halt_o}, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      rh_change_i   = (r[3:0] == 0);
      port_change_i = {r[7:4] == 0, r[7:4] == 1};
      frame_upd_i   = (r[10:8] == 0);
      frame_msb_i   = r[11];
      resume_i      = r[12] ^ (r[15:13] == 0);
      host_resume_i = (r[17:16] == 0);
      wdh_done_i    = (r[20:18] == 0);
      sched_ovr_i   = (r[23:21] == 0);
      sys_err_i     = (r[31:24] == 0);
      bus_addr_i    = ADDR_W'(r[25:24]);
      bus_wr_i      = r[26];
      bus_wdata_i   = $urandom;
      step();
      if (n % 500 == 499) do_reset();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule